// File: doc/BRIEF.md
# Three-Channel Prescaled Interval Timer

This block keeps three interval timers running from one core clock. Each channel divides the clock with its own prescaler and counts prescaled steps in a 16-bit position register. When the position reaches the channel's programmed period, a 4-bit tick counter advances and the position drops back by one period. Any excess carries into the next period. Channels 0 and 1 share a slow prescale ratio. Channel 2 runs eight times faster.

Software uses a small byte-wide register interface. It writes the three 16-bit periods one byte at a time. It sets or clears the three run bits in one control byte. It reads the tick counters, and each read returns the count and zeroes it. A synthesis parameter picks the full-rate divide ratios (256 and 32) or the half-rate ratios (128 and 16).

Top module: `tri_interval_timer`

## Requirements
- R1: The control byte sits at address 0xF1. Bit n (n = 0, 1, 2) is the run bit of channel n. The byte reads back as {5'b0, run[2:0]}.
- R2: While a channel's run bit is 0, its prescaler phase, position and tick counter keep their values. A read can still clear the tick counter.
- R3: With HALF_RATE = 0, channels 0 and 1 take one position step every 256 clock cycles and channel 2 every 32. With HALF_RATE = 1 the intervals are 128 and 16.
- R4: The prescaler phase is never discarded while a channel runs. N cycles after a channel is started with period T, its tick count is floor(N / (divide x T)) modulo 16.
- R5: When the position plus the current step is equal to or greater than the period, the tick counter gains one and the position keeps the difference. If a smaller period is written below the current position, one period is taken off per clock cycle until the position is below the period.
- R6: The tick counter is 4 bits wide and wraps from 15 to 0.
- R7: A period value of 0 acts as 65536.
- R8: A read of a tick counter returns its value and zeroes it at that clock edge. If a tick falls on the same edge, the counter holds 1 afterwards.
- R9: A write that changes a run bit from 0 to 1 sets that channel's prescaler phase and position to zero.
- R10: Period n low byte sits at 0xF2+2n and high byte at 0xF3+2n. Tick counter n reads at 0xF8+n as {4'b0, count}. rdata follows addr combinationally, and any other address reads 0. After reset every register is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe; clears an addressed tick counter |
| addr | input | 8 | Register byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |

## Verification
A write takes effect at the clock edge that samples it. A channel started at edge E makes its k-th position step at edge E + k x divide. Its tick count therefore changes only on those edges. The bench counts edges from the start write and reads at the falling edge after the last counted edge. It picks cycle counts that lie away from step edges, except where a same-edge tick is the point of the test. A lowered period drains one period per edge starting with the edge after the write, so that check reads three edges later. Reads are sampled combinationally before the clearing edge, and a second read one cycle later shows the state after the clear.

// File: rtl/tri_interval_timer.sv
module tri_interval_timer #(
  parameter bit HALF_RATE = 1'b0,
  parameter int PW = 16,
  parameter int CW = 4,
  parameter int AW = 8,
  parameter logic [AW-1:0] CTRL_ADDR = 8'hF1,
  parameter logic [AW-1:0] TGT_BASE = 8'hF2,
  parameter logic [AW-1:0] CNT_BASE = 8'hF8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  localparam int NT = 3;
  localparam int SLOW_DIV = HALF_RATE ? 128 : 256;
  localparam int FAST_DIV = SLOW_DIV / 8;
  localparam int PRW = $clog2(SLOW_DIV);

  logic [NT-1:0]   run_q;
  logic [PRW-1:0]  pre_q [NT];
  logic [PW-1:0]   pos_q [NT];
  logic [PW-1:0]   tgt_q [NT];
  logic [CW-1:0]   cnt_q [NT];

  logic [NT-1:0]   step, hit, rd_hit, rise, ctrl_wr;
  logic [PW:0]     sum [NT];
  logic [PW:0]     per [NT];
  logic [PW-1:0]   npos [NT];

  always_comb begin
    for (int i = 0; i < NT; i++) begin
      step[i]    = run_q[i] && (pre_q[i] == PRW'((i == NT-1 ? FAST_DIV : SLOW_DIV) - 1));
      per[i]     = {tgt_q[i] == '0, tgt_q[i]};
      sum[i]     = {1'b0, pos_q[i]} + (PW+1)'(step[i]);
      hit[i]     = run_q[i] && (sum[i] >= per[i]);
      npos[i]    = hit[i] ? PW'(sum[i] - per[i]) : sum[i][PW-1:0];
      rd_hit[i]  = rd_en && (addr == AW'(CNT_BASE + i));
      ctrl_wr[i] = wr_en && (addr == CTRL_ADDR);
      rise[i]    = ctrl_wr[i] && wdata[i] && !run_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      for (int i = 0; i < NT; i++) begin
        pre_q[i] <= '0;
        pos_q[i] <= '0;
        tgt_q[i] <= '0;
        cnt_q[i] <= '0;
      end
    end else begin
      if (wr_en && addr == CTRL_ADDR) run_q <= wdata[NT-1:0];
      for (int i = 0; i < NT; i++) begin
        if (rise[i]) begin
          pre_q[i] <= '0;
          pos_q[i] <= '0;
        end else if (run_q[i]) begin
          pre_q[i] <= step[i] ? '0 : pre_q[i] + 1'b1;
          pos_q[i] <= npos[i];
        end
        cnt_q[i] <= (rd_hit[i] ? '0 : cnt_q[i]) + CW'(hit[i]);
        if (wr_en && addr == AW'(TGT_BASE + 2*i))     tgt_q[i][7:0]  <= wdata;
        if (wr_en && addr == AW'(TGT_BASE + 2*i + 1)) tgt_q[i][15:8] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == CTRL_ADDR) rdata = {{(8-NT){1'b0}}, run_q};
    for (int i = 0; i < NT; i++) begin
      if (addr == AW'(TGT_BASE + 2*i))     rdata = tgt_q[i][7:0];
      if (addr == AW'(TGT_BASE + 2*i + 1)) rdata = tgt_q[i][15:8];
      if (addr == AW'(CNT_BASE + i))       rdata = {{(8-CW){1'b0}}, cnt_q[i]};
    end
  end

  for (genvar g = 0; g < NT; g++) begin : g_chk
    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!run_q[g]) && !run_q[g]) |-> ($stable(pos_q[g]) && $stable(pre_q[g])));
    assert_start_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_q[g]) |-> (pos_q[g] == '0 && pre_q[g] == '0));
    assert_read_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rd_hit[g]) |-> (cnt_q[g] <= CW'(1)));
    assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rd_hit[g]) |-> (cnt_q[g] == $past(cnt_q[g]) || cnt_q[g] == CW'($past(cnt_q[g]) + 1'b1)));
    assert_phase_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pre_q[g] < PRW'((g == NT-1 ? FAST_DIV : SLOW_DIV) - 1) || pre_q[g] == PRW'((g == NT-1 ? FAST_DIV : SLOW_DIV) - 1));
  end
endmodule

// File: tb/sim_tri_interval_timer.sv
module sim_tri_interval_timer;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = '0, wdata = '0, rdata;
  int errors = 0, checks = 0;
  logic [7:0] v;

  tri_interval_timer u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
                         .addr(addr), .wdata(wdata), .rdata(rdata));

  always #10 clk = ~clk;

  localparam int NV = 6;
  localparam int VCH [NV] = '{2, 2, 0, 1, 2, 0};
  localparam int VTG [NV] = '{3, 1, 2, 1, 0, 5};
  localparam int VN  [NV] = '{200, 549, 1100, 800, 300, 1000};
  localparam int VEX [NV] = '{2, 1, 2, 3, 0, 0};

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(posedge clk); #1 rd_en = 1'b0;
  endtask

  task automatic setup(input int ch, input int tg);
    logic [7:0] dummy;
    wr(8'hF1, 8'h00);
    wr(8'(8'hF2 + 2*ch), 8'(tg));
    wr(8'(8'hF3 + 2*ch), 8'(tg >> 8));
    rd(8'(8'hF8 + ch), dummy);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    rd(8'hF1, v); chk("R10 reset control", v, 0);
    rd(8'hF8, v); chk("R10 reset count0", v, 0);
    rd(8'hFA, v); chk("R10 reset count2", v, 0);
    rd(8'hF5, v); chk("R10 reset period1 high", v, 0);
    wr(8'hF1, 8'h05); rd(8'hF1, v); chk("R1 control readback", v, 5);
    wr(8'hF4, 8'hA5); rd(8'hF4, v); chk("R10 period1 low readback", v, 8'hA5);
    rd(8'h20, v); chk("R10 unmapped reads zero", v, 0);

    for (int k = 0; k < NV; k++) begin
      setup(VCH[k], VTG[k]);
      wr(8'hF1, 8'(1 << VCH[k]));
      repeat (VN[k]) @(posedge clk);
      rd(8'(8'hF8 + VCH[k]), v);
      // vectors cover R3 R4 R5 R6 R7
      chk($sformatf("R4 vector %0d (R3 R5 R6 R7)", k), v, VEX[k]);
    end

    setup(2, 1);
    wr(8'hF1, 8'h04);
    repeat (100) @(posedge clk);
    wr(8'hF1, 8'h00);
    repeat (200) @(posedge clk);
    rd(8'hFA, v); chk("R2 idle channel holds", v, 3);

    setup(2, 4);
    wr(8'hF1, 8'h04);
    repeat (96) @(posedge clk);
    wr(8'hF1, 8'h00);
    wr(8'hF1, 8'h04);
    repeat (96) @(posedge clk);
    rd(8'hFA, v); chk("R9 restart zeroes position", v, 0);

    setup(2, 1);
    wr(8'hF1, 8'h04);
    repeat (63) @(posedge clk);
    rd(8'hFA, v); chk("R8 value before clear", v, 1);
    rd(8'hFA, v); chk("R8 same-edge tick survives clear", v, 1);

    setup(2, 100);
    wr(8'hF1, 8'h04);
    repeat (330) @(posedge clk);
    wr(8'hF6, 8'd3);
    repeat (4) @(posedge clk);
    rd(8'hFA, v); chk("R5 lowered period drains", v, 3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule